// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host read and write on-chip program and data memory. It uses one 16-bit bus that carries both addresses and data, four strobes (select, address latch, read, write) and an acknowledge line. The strobes arrive with no timing relation to the processor clock. They pass through a synchronizer chain. Every decision the port makes is based on the synchronized copies.

The host first runs an address phase. The bus value held while the latch strobe is high is committed when that strobe falls. Bit 15 of that value decides what it loads: either a 14-bit start address with a memory-space flag, or an 8-bit overlay selection. The host then issues read or write strobes. Each one costs one cycle for synchronization and one cycle for the memory access. The address steps forward on its own, so a block of sequential words needs only one address phase.

Program words are 24 bits wide and pass through the 16-bit bus in two halves. A small request interface connects the port to memory; the memory arrays themselves are outside this block. The latched address, space flag and overlay are exported for the processor side to read.

Top module: `host_mem_port`

## Requirements
- R1: After reset, ack is 1, mem_req is 0, ovl_sel is 0 and ctl_word is 0.
- R2: An address phase is select held high while latch goes high and then low, with bus bit 15 = 0. On the latch fall, the address becomes bus bits 13:0 and the space flag becomes bus bit 14 (1 = program, 0 = data). ctl_word then shows {1'b0, space, address}.
- R3: An address phase with bus bit 15 = 1 loads ovl_sel from bus bits 7:0 and leaves ctl_word unchanged. With no latch fall, ovl_sel holds its value.
- R4: A rising select-and-(read or write) strobe is seen one clock after it is applied. From then, ack is 0 for two cycles and then returns to 1. mem_req, if raised, lasts exactly one cycle and only while ack is 0.
- R5: Data space: a write stores {8'h00, bus} at the latched address. A read returns the low 16 bits of that word on bus_out once ack returns to 1.
- R6: After every data-space access the address increases by one, wrapping within 14 bits.
- R7: Program space write: the first bus word carries bits 23:8 and the second carries bits 7:0 in bus bits 7:0. Memory is written once, after the second word, and the address then increments.
- R8: Program space read: the first read returns bits 23:8 of the word. The second returns {8'h00, bits 7:0} with no new memory request. The address increments after the second read.
- R9: Data-space writes at addresses at or above 14'h3FE0 (the control register region) raise no memory request, but the address still increments.
- R10: A new address phase restarts the program-word pairing at the upper part.
- R11: bus_oe is 1 exactly while the select and read pins are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processor clock |
| rst_n | input | 1 | active-low reset |
| h_sel | input | 1 | host select, asynchronous |
| h_latch | input | 1 | host address latch strobe |
| h_rd | input | 1 | host read strobe |
| h_wr | input | 1 | host write strobe |
| bus_in | input | 16 | multiplexed address/data from host |
| bus_out | output | 16 | read data to host |
| bus_oe | output | 1 | host bus output enable |
| ack | output | 1 | 1 when the port is ready |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_pm | output | 1 | 1 = program memory, 0 = data memory |
| mem_addr | output | 14 | memory word address |
| mem_wdata | output | 24 | memory write data |
| mem_rdata | input | 24 | memory read data, valid during request |
| ovl_sel | output | 8 | latched overlay selection |
| ctl_word | output | 16 | latched space flag and address for the processor side |

## Verification
A wrong address register shows up in two ways: in ctl_word right after the address phase, and in read data one access later, because a skipped or repeated increment returns the neighbouring word. A half-word flag out of step makes a program read return the low byte where the upper bits belong, and the mismatch appears on the very first read after the address phase. Timing faults in the handshake show at ack in the cycle after the strobe, and as a memory request count that differs from the number of words.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
    typedef enum logic {
        SPACE_DM = 1'b0,
        SPACE_PM = 1'b1
    } space_e;

    localparam int unsigned SEL_BIT_POS = 15;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain_q[i] <= '0;
                else if (i == 0)
                    chain_q[i] <= d;
                else
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hmp_engine.sv
module hmp_engine
    import hmp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned BUS_W     = 16,
    parameter int unsigned PM_W      = 24,
    parameter int unsigned OVL_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 14'h3FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sel,
    input  logic              s_lat,
    input  logic              s_rd,
    input  logic              s_wr,
    input  logic [BUS_W-1:0]  s_bus,
    output logic [BUS_W-1:0]  rd_data,
    output logic              ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_pm,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PM_W-1:0]   mem_wdata,
    input  logic [PM_W-1:0]   mem_rdata,
    output logic [OVL_W-1:0]  ovl_sel,
    output logic              space_pm
);
    localparam int unsigned LO_W = PM_W - BUS_W;

    typedef struct packed {
        logic              busy;
        logic              lat_p;
        logic              acc_p;
        logic              is_wr;
        logic              pm;
        logic              half;
        logic [ADDR_W-1:0] addr;
        logic [OVL_W-1:0]  ovl;
        logic [BUS_W-1:0]  lbus;
        logic [BUS_W-1:0]  wdat;
        logic [BUS_W-1:0]  hi_w;
        logic [LO_W-1:0]   hold_lo;
        logic [BUS_W-1:0]  rdat;
    } eng_t;

    eng_t st_d, st_q;
    logic acc_now, start, lat_fall, last;

    always_comb begin
        st_d     = st_q;
        acc_now  = s_sel & (s_rd | s_wr);
        lat_fall = st_q.lat_p & ~s_lat & s_sel;
        start    = acc_now & ~st_q.acc_p & ~st_q.busy;
        last     = ~st_q.pm | st_q.half;

        st_d.lat_p = s_lat;
        st_d.acc_p = acc_now;
        if (s_sel && s_lat)
            st_d.lbus = s_bus;

        if (start) begin
            st_d.busy  = 1'b1;
            st_d.is_wr = s_wr;
            st_d.wdat  = s_bus;
        end

        if (st_q.busy) begin
            st_d.busy = 1'b0;
            if (st_q.pm)
                st_d.half = ~st_q.half;
            if (!st_q.is_wr) begin
                if (st_q.pm && !st_q.half) begin
                    st_d.rdat    = mem_rdata[PM_W-1:LO_W];
                    st_d.hold_lo = mem_rdata[LO_W-1:0];
                end else if (st_q.pm) begin
                    st_d.rdat = {{(BUS_W-LO_W){1'b0}}, st_q.hold_lo};
                end else begin
                    st_d.rdat = mem_rdata[BUS_W-1:0];
                end
            end else if (st_q.pm && !st_q.half) begin
                st_d.hi_w = st_q.wdat;
            end
            if (last)
                st_d.addr = st_q.addr + 1'b1;
        end

        if (lat_fall) begin
            if (st_q.lbus[SEL_BIT_POS]) begin
                st_d.ovl = st_q.lbus[OVL_W-1:0];
            end else begin
                st_d.pm   = st_q.lbus[ADDR_W];
                st_d.addr = st_q.lbus[ADDR_W-1:0];
            end
            st_d.half = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        mem_we   = st_q.busy & st_q.is_wr;
        mem_pm   = st_q.pm;
        mem_addr = st_q.addr;
        if (st_q.is_wr)
            mem_req = st_q.busy & (st_q.pm ? st_q.half : (st_q.addr < CTRL_BASE));
        else
            mem_req = st_q.busy & (st_q.pm ? ~st_q.half : 1'b1);
        if (st_q.pm)
            mem_wdata = {st_q.hi_w, st_q.wdat[LO_W-1:0]};
        else
            mem_wdata = {{LO_W{1'b0}}, st_q.wdat};
    end

    assign ack      = ~st_q.busy & ~start;
    assign rd_data  = st_q.rdat;
    assign ovl_sel  = st_q.ovl;
    assign space_pm = (st_q.pm == SPACE_PM);

    // R4
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R4
    req_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ack);
    // R9
    ctrl_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_pm) |-> (mem_addr < CTRL_BASE));
    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && last && !lat_fall) |=> (st_q.addr == $past(st_q.addr) + 1'b1));
    // R3
    ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_fall |=> $stable(st_q.ovl));
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port #(
    parameter int unsigned ADDR_W      = 14,
    parameter int unsigned BUS_W       = 16,
    parameter int unsigned PM_W        = 24,
    parameter int unsigned OVL_W       = 8,
    parameter int unsigned SYNC_STAGES = 1,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 14'h3FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_sel,
    input  logic              h_latch,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe,
    output logic              ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_pm,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PM_W-1:0]   mem_wdata,
    input  logic [PM_W-1:0]   mem_rdata,
    output logic [OVL_W-1:0]  ovl_sel,
    output logic [BUS_W-1:0]  ctl_word
);
    localparam int unsigned SYNC_W = BUS_W + 4;

    logic [SYNC_W-1:0] s_vec;
    logic              space_pm;

    hmp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({h_sel, h_latch, h_rd, h_wr, bus_in}),
        .q     (s_vec)
    );

    hmp_engine #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .PM_W(PM_W), .OVL_W(OVL_W), .CTRL_BASE(CTRL_BASE)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_sel     (s_vec[BUS_W+3]),
        .s_lat     (s_vec[BUS_W+2]),
        .s_rd      (s_vec[BUS_W+1]),
        .s_wr      (s_vec[BUS_W]),
        .s_bus     (s_vec[BUS_W-1:0]),
        .rd_data   (bus_out),
        .ack       (ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_pm    (mem_pm),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .ovl_sel   (ovl_sel),
        .space_pm  (space_pm)
    );

    assign bus_oe   = h_sel & h_rd;
    assign ctl_word = {{(BUS_W-ADDR_W-1){1'b0}}, space_pm, mem_addr};

    // R11
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sel && h_wr && !h_rd) |-> !bus_oe);
endmodule

// File: tb/test_host_mem_port.sv
module test_host_mem_port;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 15;
    // kind: 0 = address phase, 1 = write, 2 = read with expected data
    localparam logic [33:0] VEC [NVEC] = '{
        {2'd0, 16'h0010, 16'h0000},
        {2'd1, 16'h1234, 16'h0000},
        {2'd1, 16'hBEEF, 16'h0000},
        {2'd0, 16'h0010, 16'h0000},
        {2'd2, 16'h0000, 16'h1234},
        {2'd2, 16'h0000, 16'hBEEF},
        {2'd0, 16'h4005, 16'h0000},
        {2'd1, 16'hA1B2, 16'h0000},
        {2'd1, 16'h00C3, 16'h0000},
        {2'd1, 16'h1122, 16'h0000},
        {2'd1, 16'h0033, 16'h0000},
        {2'd0, 16'h4005, 16'h0000},
        {2'd2, 16'h0000, 16'hA1B2},
        {2'd2, 16'h0000, 16'h00C3},
        {2'd2, 16'h0000, 16'h1122}
    };

    logic clk = 0, rst_n = 0;
    logic h_sel = 0, h_latch = 0, h_rd = 0, h_wr = 0;
    logic [15:0] bus_in = '0, bus_out, ctl_word;
    logic bus_oe, ack, mem_req, mem_we, mem_pm;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata, mem_rdata;
    logic [7:0] ovl_sel;
    logic [23:0] pm_mem [64];
    logic [15:0] dm_mem [64];
    int errors = 0, checks = 0, wr_count = 0, req_count = 0;
    logic [15:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_mem_port i_host_mem_port (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_latch(h_latch), .h_rd(h_rd),
        .h_wr(h_wr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ack(ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_pm(mem_pm), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ovl_sel(ovl_sel),
        .ctl_word(ctl_word)
    );

    assign mem_rdata = mem_pm ? pm_mem[mem_addr[5:0]] : {8'h00, dm_mem[mem_addr[5:0]]};

    always @(posedge clk) begin
        if (mem_req) req_count <= req_count + 1;
        if (mem_req && mem_we) begin
            wr_count <= wr_count + 1;
            if (mem_pm) pm_mem[mem_addr[5:0]] <= mem_wdata;
            else        dm_mem[mem_addr[5:0]] <= mem_wdata[15:0];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [15:0] v);
        @(negedge clk); bus_in = v; h_sel = 1; h_latch = 1;
        repeat (2) @(negedge clk);
        h_latch = 0;
        repeat (3) @(negedge clk);
        h_sel = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic access(input logic wr, input logic [15:0] v, output logic [15:0] got);
        @(negedge clk); bus_in = v; h_sel = 1; h_rd = !wr; h_wr = wr;
        repeat (3) @(negedge clk);
        got = bus_out;
        h_rd = 0; h_wr = 0; h_sel = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin pm_mem[i] = '0; dm_mem[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ack", ack, 1); check("R1 mem_req", mem_req, 0);
        check("R1 ovl", ovl_sel, 0); check("R1 ctl_word", ctl_word, 0);
        rst_n = 1;
        @(negedge clk);

        // vector walk: R2, R5, R7, R8
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][33:32])
                2'd0: addr_phase(VEC[i][31:16]);
                2'd1: access(1'b1, VEC[i][31:16], rd_val);
                default: begin
                    access(1'b0, 16'h0, rd_val);
                    check($sformatf("R5/R8 vec%0d", i), rd_val, VEC[i][15:0]);
                end
            endcase
        end
        check("R7 pm word", pm_mem[5], 24'hA1B2C3);

        // R2 space flag and address in ctl_word
        addr_phase(16'h4005);
        check("R2 ctl_word", ctl_word, 16'h4005);
        // R3 overlay load leaves address alone
        addr_phase(16'h8012);
        check("R3 ovl", ovl_sel, 8'h12);
        check("R3 ctl unchanged", ctl_word, 16'h4005);
        // R10 restart upper half after partial read
        access(1'b0, 16'h0, rd_val);
        addr_phase(16'h4005);
        access(1'b0, 16'h0, rd_val);
        check("R10 restart upper", rd_val, 16'hA1B2);
        access(1'b0, 16'h0, rd_val);
        check("R8 second half", rd_val, 16'h00C3);
        check("R8 step after pair", ctl_word, 16'h4006);

        // R4 ack timing and single request, R11 oe on write
        addr_phase(16'h0020);
        req_count = 0;
        @(negedge clk); bus_in = 16'h7777; h_sel = 1; h_wr = 1;
        check("R11 oe during write", bus_oe, 0);
        check("R4 ack before sync", ack, 1);
        @(negedge clk); check("R4 ack low 1", ack, 0);
        @(negedge clk); check("R4 ack low 2", ack, 0);
        @(negedge clk); check("R4 ack back", ack, 1);
        h_wr = 0; h_sel = 0;
        repeat (2) @(negedge clk);
        check("R4 one request", req_count, 1);
        check("R6 dm step", ctl_word, 16'h0021);
        check("R5 dm stored", dm_mem[32], 16'h7777);
        h_sel = 1; h_rd = 1;
        @(negedge clk); check("R11 oe during read", bus_oe, 1);
        h_sel = 0; h_rd = 0;
        repeat (2) @(negedge clk);

        // R9 protected control region
        addr_phase(16'h3FE1);
        wr_count = 0;
        access(1'b1, 16'h5555, rd_val);
        check("R9 no write", wr_count, 0);
        check("R9 still steps", ctl_word, 16'h3FE2);

        // R6 wrap in program space
        addr_phase(16'h7FFF);
        access(1'b0, 16'h0, rd_val);
        access(1'b0, 16'h0, rd_val);
        check("R6 wrap", ctl_word, 16'h4000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule